// File: doc/BRIEF.md
# Multichannel DMA Transfer Controller

This block moves data units between locations on a single-master memory bus with a 24-bit address space. Software programs each channel through a small write port. The port holds a wide address, a narrow address, a transfer count and a control byte per channel, plus one global bit that picks the address configuration. When a channel is enabled and its request line is high, or its auto-request bit is set, the engine arbitrates and moves one unit. In block transfers it moves a whole block. At the end of the count it emits a one-cycle end pulse.

In short-address configuration there are four channels. Each pairs a 24-bit address with a 16-bit address, and the 16-bit address sits in the top 64 KiB of the space. A short channel can run in dual-address mode, where a read cycle is followed by a write cycle. It can also run in single-address mode, where there is one bus cycle on the 24-bit address and an acknowledge strobe serves the peripheral side. In full-address configuration, neighbouring register slots pair up into two channels. Each of these channels has a 24-bit source and a 24-bit destination, and it runs in normal or block mode.

Top module: `dmac_top`

## Requirements
- R1: After reset, and while no channel is enabled, there is no bus cycle. The end pulses and acknowledges stay low, even when request lines are high.
- R2: In short dual-address mode, each unit is a read at the source followed by a write of the read data at the destination, and read and write are never driven together. Control bit 3 = 0 makes the wide address the source and the narrow address the destination. Bit 3 = 1 swaps them. The narrow address is placed on the bus with bits 23:16 all ones.
- R3: Control bit 1 selects the unit size (0 = byte, 1 = 16-bit word). The bus size output follows it, and a stepping address advances by 1 or 2 per unit.
- R4: Sequential mode (control bits 5:4 = 0) steps the wide address and leaves the narrow address fixed. It decrements the count per unit. On the unit that takes the count to zero it pulses the channel's end output for exactly one cycle and clears the enable bit (bit 0), so a held request then causes no further cycle.
- R5: Idle mode (bits 5:4 = 1) keeps both addresses fixed for every unit.
- R6: Repeat mode (bits 5:4 = 2) pulses the end output at zero count, reloads the wide address and the count with their last written values, and keeps the channel enabled.
- R7: Single-address mode (bit 2 = 1, short configuration only) uses one bus cycle per unit on the wide address and asserts only that channel's acknowledge during the cycle. Bit 3 = 0 makes the cycle a read and bit 3 = 1 makes it a write.
- R8: Among eligible channels, the lowest index wins. Arbitration happens only between units, so a unit that has started always finishes before another channel is served.
- R9: With the global bit set, logical channel k uses register slot 2k as source and slot 2k+1 as destination, with its count, control and block size in slot 2k. Both addresses step by the unit size.
- R10: Block mode (control bit 7, full configuration) moves a whole block per grant. The block holds as many units as slot 2k's narrow register, with no rearbitration inside the block, and the count is in blocks.
- R11: Each bus cycle holds its address and strobe until the ready input is seen high.
- R12: Control bit 6 (auto-request) starts and sustains transfers with the request line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Bit 4 global select. Otherwise bits 3:2 channel slot and bits 1:0 register (0 wide address, 1 narrow address/block size, 2 count, 3 control) |
| reg_wdata | input | 24 | Register write data |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge during a single-address cycle |
| tend | output | 4 | Per-channel one-cycle transfer-end pulse |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | Unit is a 16-bit word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Bus cycle completes on this clock |

## Verification
A wrong address register or a wrong step shows at the next unit as an unexpected address in the bus trace. This happens a few cycles after the fault, because every unit places its addresses on the bus. A count or enable fault shows as an end pulse on the wrong unit, or as extra or missing cycles while a request is held. Arbitration or block-state faults show as interleaving in the trace that differs from the priority order the requirements imply. The checks compare the full ordered trace of bus cycles, acknowledges and end pulses with lists built from the programmed values.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_SGL} dma_state_e;

  // control byte, bit 0 first from the right
  typedef struct packed {
    logic       blk;       // 7: block transfer (full configuration)
    logic       auto_req;  // 6: software start
    logic [1:0] op;        // 5:4: sequential / idle / repeat
    logic       swap;      // 3: direction select
    logic       sgl;       // 2: single-address cycle
    logic       word;      // 1: 16-bit unit
    logic       en;        // 0: channel enable
  } dma_ctl_t;

  localparam logic [1:0] OP_SEQ  = 2'd0;
  localparam logic [1:0] OP_HOLD = 2'd1;
  localparam logic [1:0] OP_RPT  = 2'd2;
endpackage

// File: rtl/dmac_prio_arb.sv
module dmac_prio_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          hit,
  output logic [IW-1:0] sel
);
  always_comb begin
    hit = |elig;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) sel = IW'(i);
    end
  end
endmodule

// File: rtl/dmac_addr_map.sv
module dmac_addr_map #(
  parameter int AW = 24,
  parameter int NW = 16
) (
  input  logic          full,
  input  logic          swap,
  input  logic [AW-1:0] wide_a,
  input  logic [AW-1:0] wide_b,
  input  logic [NW-1:0] narrow,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst
);
  logic [AW-1:0] ext;
  assign ext = {{(AW-NW){1'b1}}, narrow};

  always_comb begin
    if (full) begin
      src = wide_a;
      dst = wide_b;
    end else if (swap) begin
      src = ext;
      dst = wide_a;
    end else begin
      src = wide_a;
      dst = ext;
    end
  end
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 24,
  parameter int NW     = 16,
  parameter int CW     = 16,
  parameter int DW     = 16,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int RAW   = CHW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  input  logic [NUM_CH-1:0] dreq,
  output logic [NUM_CH-1:0] dack,
  output logic [NUM_CH-1:0] tend,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_word,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);
  logic [AW-1:0] wide_q  [NUM_CH];
  logic [AW-1:0] wide_sh [NUM_CH];
  logic [NW-1:0] narrow_q[NUM_CH];
  logic [CW-1:0] cnt_q   [NUM_CH];
  logic [CW-1:0] cnt_sh  [NUM_CH];
  dma_ctl_t      ctl_q   [NUM_CH];

  logic              full_q;
  dma_state_e        st;
  logic [CHW-1:0]    cur_k, cur_p, pn, sel, sel_p, wch;
  logic [NW-1:0]     bcnt;
  logic [DW-1:0]     data_q;
  logic [NUM_CH-1:0] done_q, elig;
  logic              hit, last_in_blk, cnt_last;
  logic [AW-1:0]     src, dst, step;
  dma_ctl_t          cc;

  function automatic logic [CHW-1:0] phys(input logic [CHW-1:0] k, input logic f);
    return f ? {k[CHW-2:0], 1'b0} : k;
  endfunction

  // which logical channels may start a unit now
  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      logic [CHW-1:0] p;
      p = phys(CHW'(k), full_q);
      elig[k] = (!full_q || k < NUM_CH / 2) && ctl_q[p].en &&
                (dreq[k] || ctl_q[p].auto_req);
    end
  end

  dmac_prio_arb #(.N(NUM_CH), .IW(CHW)) u_arb (
    .elig (elig),
    .hit  (hit),
    .sel  (sel)
  );

  assign sel_p = phys(sel, full_q);
  assign pn    = cur_p + CHW'(1);
  assign cc    = ctl_q[cur_p];
  assign wch   = reg_addr[CHW+1:2];
  assign step  = cc.word ? AW'(2) : AW'(1);
  assign last_in_blk = !(full_q && cc.blk) || (bcnt == NW'(1));
  assign cnt_last    = (cnt_q[cur_p] == CW'(1));

  dmac_addr_map #(.AW(AW), .NW(NW)) u_map (
    .full   (full_q),
    .swap   (cc.swap),
    .wide_a (wide_q[cur_p]),
    .wide_b (wide_q[pn]),
    .narrow (narrow_q[cur_p]),
    .src    (src),
    .dst    (dst)
  );

  // bus side, decoded from the state register
  always_comb begin
    bus_rd   = (st == ST_RD) || (st == ST_SGL && !cc.swap);
    bus_wr   = (st == ST_WR) || (st == ST_SGL && cc.swap);
    bus_word = (st != ST_IDLE) && cc.word;
    case (st)
      ST_RD:   bus_addr = src;
      ST_WR:   bus_addr = dst;
      ST_SGL:  bus_addr = wide_q[cur_p];
      default: bus_addr = '0;
    endcase
    dack = '0;
    if (st == ST_SGL) dack[cur_k] = 1'b1;
  end

  assign bus_wdata = data_q;
  assign tend      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      full_q <= 1'b0;
      done_q <= '0;
      cur_k  <= '0;
      cur_p  <= '0;
      bcnt   <= '0;
      data_q <= '0;
      for (int c = 0; c < NUM_CH; c++) ctl_q[c] <= '0;
    end else begin
      done_q <= '0;
      case (st)
        ST_IDLE: begin
          if (hit) begin
            cur_k <= sel;
            cur_p <= sel_p;
            bcnt  <= narrow_q[sel_p];
            st    <= (!full_q && ctl_q[sel_p].sgl) ? ST_SGL : ST_RD;
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            data_q <= bus_rdata;
            st     <= ST_WR;
          end
        end
        default: begin
          if (bus_ready) begin
            if (full_q) begin
              wide_q[cur_p] <= wide_q[cur_p] + step;
              wide_q[pn]    <= wide_q[pn] + step;
            end else if (cc.op != OP_HOLD) begin
              wide_q[cur_p] <= wide_q[cur_p] + step;
            end
            if (!last_in_blk) begin
              bcnt <= bcnt - NW'(1);
              st   <= ST_RD;
            end else begin
              st           <= ST_IDLE;
              cnt_q[cur_p] <= cnt_q[cur_p] - CW'(1);
              if (cnt_last) begin
                done_q[cur_k] <= 1'b1;
                if (!full_q && cc.op == OP_RPT) begin
                  wide_q[cur_p] <= wide_sh[cur_p];
                  cnt_q[cur_p]  <= cnt_sh[cur_p];
                end else begin
                  ctl_q[cur_p].en <= 1'b0;
                end
              end
            end
          end
        end
      endcase
      // software writes win over engine updates in the same cycle
      if (reg_we) begin
        if (reg_addr[RAW-1]) begin
          full_q <= reg_wdata[0];
        end else begin
          case (reg_addr[1:0])
            2'd0: begin
              wide_q[wch]  <= reg_wdata;
              wide_sh[wch] <= reg_wdata;
            end
            2'd1: narrow_q[wch] <= reg_wdata[NW-1:0];
            2'd2: begin
              cnt_q[wch]  <= reg_wdata[CW-1:0];
              cnt_sh[wch] <= reg_wdata[CW-1:0];
            end
            default: ctl_q[wch] <= dma_ctl_t'(reg_wdata[7:0]);
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] dack,
  input logic [NUM_CH-1:0] tend,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ready
);
  assert_quiet_after_rst_R1: assert property (@(posedge clk)
    rst |=> (!bus_rd && !bus_wr && tend == '0 && dack == '0));

  assert_one_direction_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  assert_end_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (tend != '0) |=> (tend == '0));

  assert_end_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tend));

  assert_ack_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (dack != '0) |-> ((bus_rd || bus_wr) && $onehot(dack)));

  assert_rd_held_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

  assert_wr_held_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr)));
endmodule

bind dmac_top dmac_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dack      (dack),
  .tend      (tend),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ready (bus_ready)
);

// File: tb/sim_dmac_top.sv
module sim_dmac_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack, tend;
  logic [23:0] bus_addr;
  logic        bus_rd, bus_wr, bus_word;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rdy = 1'b0;

  always #2 clk = ~clk;

  dmac_top u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dreq(dreq), .dack(dack), .tend(tend),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(rdy)
  );

  assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

  int n_chk = 0, n_fail = 0, waits = 0, wcnt = 0, log_n = 0;
  int l_addr[64], l_wr[64], l_data[64], l_ack[64], l_word[64];
  int done_cnt[4];
  bit finished = 0;

  // bus model and trace, all at the falling edge
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) done_cnt[k] += int'(tend[k]);
    if (rst || rdy) begin
      rdy  = 1'b0;
      wcnt = 0;
    end else if (bus_rd || bus_wr) begin
      if (wcnt >= waits) begin
        if (log_n < 64) begin
          l_addr[log_n] = int'(bus_addr);
          l_wr[log_n]   = int'(bus_wr);
          l_data[log_n] = bus_wr ? int'(bus_wdata) : int'(bus_rdata);
          l_ack[log_n]  = int'(dack);
          l_word[log_n] = int'(bus_word);
        end
        log_n++;
        rdy = 1'b1;
      end else wcnt++;
    end
  end

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dreq = '0; reg_we = 1'b0; waits = 0;
    repeat (3) @(negedge clk);
    log_n = 0;
    for (int k = 0; k < 4; k++) done_cnt[k] = 0;
    rst = 1'b0;
  endtask

  task automatic wreg(int ch, int sel, int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {1'b0, 2'(ch), 2'(sel)}; reg_wdata = 24'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wglob(int f);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'b10000; reg_wdata = 24'(f);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_log(int n);
    for (int i = 0; i < 400 && log_n < n; i++) @(posedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    dreq = 4'hF;
    run(20);
    check("R1 rd", int'(bus_rd), 0);
    check("R1 wr", int'(bus_wr), 0);
    check("R1 tend", int'(tend), 0);
    check("R1 dack", int'(dack), 0);
    check("R1 no cycles", log_n, 0);
  endtask

  task automatic t_seq();
    do_reset();
    wreg(1, 0, 24'h012340); wreg(1, 1, 16'h0800); wreg(1, 2, 3);
    dreq[1] = 1'b1;
    wreg(1, 3, 8'h01);
    run(80);
    check("R2 read src", l_addr[0], 24'h012340);
    check("R2 read dir", l_wr[0], 0);
    check("R2 dst ext", l_addr[1], 24'hFF0800);
    check("R2 write dir", l_wr[1], 1);
    check("R2 data", l_data[1], 16'h8683);
    check("R3 byte step", l_addr[2], 24'h012341);
    check("R4 step", l_addr[4], 24'h012342);
    check("R4 narrow fixed", l_addr[5], 24'hFF0800);
    check("R4 stops", log_n, 6);
    check("R4 end", done_cnt[1], 1);
  endtask

  task automatic t_word_swap();
    do_reset();
    wreg(2, 0, 24'h000200); wreg(2, 1, 16'h1000); wreg(2, 2, 2);
    wreg(2, 3, 8'h4B);
    run(60);
    check("R2 swap src", l_addr[0], 24'hFF1000);
    check("R2 swap dst", l_addr[1], 24'h000200);
    check("R3 word flag", l_word[0], 1);
    check("R3 word step", l_addr[3], 24'h000202);
    check("R12 auto count", log_n, 4);
    check("R12 auto end", done_cnt[2], 1);
  endtask

  task automatic t_hold();
    do_reset();
    wreg(0, 0, 24'h000050); wreg(0, 1, 16'h0010); wreg(0, 2, 2);
    wreg(0, 3, 8'h51);
    run(60);
    check("R5 src fixed", l_addr[2], 24'h000050);
    check("R5 dst fixed", l_addr[3], 24'hFF0010);
    check("R5 count", log_n, 4);
  endtask

  task automatic t_repeat();
    do_reset();
    wreg(3, 0, 24'h000300); wreg(3, 1, 16'h0040); wreg(3, 2, 2);
    dreq[3] = 1'b1;
    wreg(3, 3, 8'h21);
    wait_log(10);
    dreq[3] = 1'b0;
    run(20);
    check("R6 a0", l_addr[0], 24'h000300);
    check("R6 a1", l_addr[2], 24'h000301);
    check("R6 reload", l_addr[4], 24'h000300);
    check("R6 a3", l_addr[6], 24'h000301);
    check("R6 reload2", l_addr[8], 24'h000300);
    check("R6 ends", int'(done_cnt[3] >= 2), 1);
  endtask

  task automatic t_single();
    do_reset();
    wreg(1, 0, 24'h004000); wreg(1, 2, 2);
    dreq[1] = 1'b1;
    wreg(1, 3, 8'h05);
    run(40);
    check("R7 count", log_n, 2);
    check("R7 rd", l_wr[0], 0);
    check("R7 addr", l_addr[1], 24'h004001);
    check("R7 ack", l_ack[0], 4'b0010);
    wreg(1, 2, 1); wreg(1, 3, 8'h0D);
    run(30);
    check("R7 write", l_wr[2], 1);
    check("R7 waddr", l_addr[2], 24'h004002);
    check("R7 total", log_n, 3);
  endtask

  task automatic t_prio();
    do_reset();
    wreg(0, 0, 24'h000000); wreg(0, 1, 16'h0100); wreg(0, 2, 2);
    wreg(2, 0, 24'h002000); wreg(2, 1, 16'h0200); wreg(2, 2, 2);
    wreg(2, 3, 8'h41);
    wreg(0, 3, 8'h41);
    run(80);
    check("R8 first", l_addr[0], 24'h002000);
    check("R8 unsplit", l_addr[1], 24'hFF0200);
    check("R8 ch0 wins", l_addr[2], 24'h000000);
    check("R8 ch0 next", l_addr[4], 24'h000001);
    check("R8 ch2 resumes", l_addr[6], 24'h002001);
  endtask

  task automatic t_full();
    do_reset();
    waits = 3;
    wglob(1);
    wreg(0, 0, 24'h100000); wreg(1, 0, 24'h200000); wreg(0, 2, 2);
    wreg(0, 3, 8'h43);
    run(100);
    check("R9 src", l_addr[0], 24'h100000);
    check("R9 dst", l_addr[1], 24'h200000);
    check("R11 data", l_data[1], 16'hA5C3);
    check("R9 src step", l_addr[2], 24'h100002);
    check("R9 dst step", l_addr[3], 24'h200002);
    check("R11 count", log_n, 4);
    check("R9 end", done_cnt[0], 1);
  endtask

  task automatic t_block();
    do_reset();
    wglob(1);
    wreg(2, 0, 24'h300000); wreg(3, 0, 24'h310000); wreg(2, 1, 3); wreg(2, 2, 1);
    wreg(0, 0, 24'h400000); wreg(1, 0, 24'h410000); wreg(0, 2, 1); wreg(0, 3, 8'h01);
    wreg(2, 3, 8'hC1);
    wait_log(1);
    dreq[0] = 1'b1;
    run(80);
    check("R10 u0", l_addr[0], 24'h300000);
    check("R10 u1", l_addr[2], 24'h300001);
    check("R10 u2", l_addr[4], 24'h300002);
    check("R10 u2 dst", l_addr[5], 24'h310002);
    check("R10 then ch0", l_addr[6], 24'h400000);
    check("R10 ch0 dst", l_addr[7], 24'h410000);
    check("R10 total", log_n, 8);
    check("R10 end ch1", done_cnt[1], 1);
    check("R10 end ch0", done_cnt[0], 1);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_word_swap();
    t_hold();
    t_repeat();
    t_single();
    t_prio();
    t_full();
    t_block();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule